// File: doc/BRIEF.md
# Packet Timestamp Normaliser

This block turns raw hardware timestamps, captured when a packet is received or sent, into one flat 64-bit count of nanoseconds. A mode input chooses between two capture formats.

In the split format, the upper half of the captured word holds whole seconds and the lower half holds the nanoseconds within that second. The block multiplies the seconds by one billion and adds the nanoseconds. Receive and transmit stamps are treated the same way.

In the legacy format the two directions differ. A receive stamp was stored with its bytes in big-endian order, so its eight bytes are reversed. A transmit stamp is already a nanosecond count and passes through unchanged. In both formats, a transmit slot holding the value one means no stamp was captured: the block marks that result as empty and does not convert it.

Stamps enter and leave on valid/ready streams. Each result keeps its direction flag and comes out two cycles after it was accepted. Backpressure on the output holds the whole pipeline.

Top module: `stamp_normalizer`

## Requirements
- R1: With `modeNew`=1, a receive stamp produces `outNs` = `inStamp[63:32]` × 1,000,000,000 + `inStamp[31:0]`, and `outNoStamp`=0.
- R2: With `modeNew`=1, a transmit stamp other than the value 1 gets the same seconds/nanoseconds conversion as a receive stamp, and `outIsTx`=1.
- R3: With `modeNew`=0, a receive stamp comes out with its bytes reversed: result byte k (bits 8k+7..8k) equals input byte 7−k.
- R4: With `modeNew`=0, a transmit stamp other than the value 1 comes out unchanged.
- R5: A transmit stamp equal to 1 gives `outNoStamp`=1 and `outNs`=0 in either mode. A receive stamp equal to 1 is converted normally.
- R6: While `outReady` is held high, a stamp accepted on a clock edge (`inValid` and `inReady` both high) appears with `outValid`=1 after exactly two more rising edges. `outIsTx` equals the direction flag of that transfer.
- R7: While `outValid`=1 and `outReady`=0, `inReady` is 0 and `outNs`, `outIsTx` and `outNoStamp` hold their values. Every accepted stamp leaves in order, and none is lost or repeated.
- R8: The format mode is taken at the moment of acceptance. Changing `modeNew` afterwards does not alter a stamp already inside the pipeline.
- R9: While `rstN` is low and on the first cycle after it, `outValid` is 0.
- R10: With `outReady` held high, `inReady` stays 1, so one stamp is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input stamp is valid |
| inReady | output | 1 | Block can accept a stamp this cycle |
| inStamp | input | 64 | Raw captured timestamp word |
| inIsTx | input | 1 | 1 = transmit stamp, 0 = receive stamp |
| modeNew | input | 1 | 1 = seconds/nanoseconds format, 0 = legacy format |
| outValid | output | 1 | Result is valid |
| outReady | input | 1 | Consumer takes the result |
| outNs | output | 64 | Normalised nanosecond value |
| outIsTx | output | 1 | Direction flag carried with the result |
| outNoStamp | output | 1 | Transmit slot held no stamp |

## Verification
The checker watches the stream handshake on every cycle. It checks that a stalled result stays frozen and that input is refused during a stall. It checks that no result appears without an acceptance two cycles earlier, that an empty-slot result reads zero on a transmit flag, and that the output is idle after reset. The arithmetic cannot be judged by these properties, since they do not know the mode a stamp was accepted under. That covers the seconds-times-billion sum, the byte reversal, the pass-through, the per-transfer capture of the mode, and in-order delivery with nothing lost. Only the bench shows these, by comparing each result with a model value computed at acceptance.

// File: rtl/stamp_norm_pkg.sv
package stamp_norm_pkg;
  localparam int STAMP_W = 64;
  localparam int HALF_W  = STAMP_W / 2;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = STAMP_W / BYTE_W;
  localparam int SCALE_W = 30;
  localparam logic [SCALE_W-1:0] NS_PER_SEC = 30'd1000000000;

  typedef enum logic [1:0] {
    KIND_SECNS   = 2'd0,
    KIND_SWAP    = 2'd1,
    KIND_PASS    = 2'd2,
    KIND_NOSTAMP = 2'd3
  } convKind_t;

  typedef struct packed {
    logic cap1;
    logic cap2;
  } pipeStrobe_t;
endpackage

// File: rtl/stamp_norm_ctrl.sv
module stamp_norm_ctrl
  import stamp_norm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic        outReady,
  output logic        outValid,
  output pipeStrobe_t strobe
);
  logic valid1;
  logic valid2;
  logic adv;

  assign adv         = !valid2 || outReady;
  assign inReady     = adv;
  assign strobe.cap1 = inValid && adv;
  assign strobe.cap2 = valid1 && adv;
  assign outValid    = valid2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else if (adv) begin
      valid1 <= inValid;
      valid2 <= valid1;
    end
  end
endmodule

// File: rtl/stamp_norm_dp.sv
module stamp_norm_dp
  import stamp_norm_pkg::*;
#(
  parameter int SPLIT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pipeStrobe_t        strobe,
  input  logic [STAMP_W-1:0] inStamp,
  input  logic               inIsTx,
  input  logic               modeNew,
  output logic [STAMP_W-1:0] outNs,
  output logic               outIsTx,
  output logic               outNoStamp
);
  localparam int HI_W  = HALF_W - SPLIT_W;
  localparam int PPH_W = HI_W + SCALE_W;
  localparam int PPL_W = SPLIT_W + SCALE_W;

  logic [STAMP_W-1:0] swapped;
  logic [HI_W-1:0]    secHi;
  logic [SPLIT_W-1:0] secLo;
  logic [HALF_W-1:0]  nsecIn;
  convKind_t          kindNext;
  logic [STAMP_W-1:0] wordNext;

  logic [PPH_W-1:0]   s1PpHi;
  logic [PPL_W-1:0]   s1PpLo;
  logic [STAMP_W-1:0] s1Word;
  convKind_t          s1Kind;
  logic               s1IsTx;
  logic [STAMP_W-1:0] s2Next;

  for (genvar b = 0; b < N_BYTES; b++) begin : gSwap
    assign swapped[b*BYTE_W +: BYTE_W] = inStamp[(N_BYTES-1-b)*BYTE_W +: BYTE_W];
  end

  assign secHi  = inStamp[STAMP_W-1 -: HI_W];
  assign secLo  = inStamp[HALF_W +: SPLIT_W];
  assign nsecIn = inStamp[HALF_W-1:0];

  always_comb begin
    if (inIsTx && inStamp == STAMP_W'(1)) kindNext = KIND_NOSTAMP;
    else if (modeNew)                     kindNext = KIND_SECNS;
    else if (inIsTx)                      kindNext = KIND_PASS;
    else                                  kindNext = KIND_SWAP;
  end

  always_comb begin
    case (kindNext)
      KIND_SECNS: wordNext = STAMP_W'(nsecIn);
      KIND_SWAP:  wordNext = swapped;
      KIND_PASS:  wordNext = inStamp;
      default:    wordNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1PpHi <= '0;
      s1PpLo <= '0;
      s1Word <= '0;
      s1Kind <= KIND_NOSTAMP;
      s1IsTx <= 1'b0;
    end else if (strobe.cap1) begin
      s1PpHi <= PPH_W'(secHi) * PPH_W'(NS_PER_SEC);
      s1PpLo <= PPL_W'(secLo) * PPL_W'(NS_PER_SEC);
      s1Word <= wordNext;
      s1Kind <= kindNext;
      s1IsTx <= inIsTx;
    end
  end

  always_comb begin
    case (s1Kind)
      KIND_SECNS:   s2Next = (STAMP_W'(s1PpHi) << SPLIT_W) + STAMP_W'(s1PpLo) + s1Word;
      KIND_NOSTAMP: s2Next = '0;
      default:      s2Next = s1Word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outNs      <= '0;
      outIsTx    <= 1'b0;
      outNoStamp <= 1'b0;
    end else if (strobe.cap2) begin
      outNs      <= s2Next;
      outIsTx    <= s1IsTx;
      outNoStamp <= (s1Kind == KIND_NOSTAMP);
    end
  end
endmodule

// File: rtl/stamp_normalizer.sv
module stamp_normalizer
  import stamp_norm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [STAMP_W-1:0] inStamp,
  input  logic               inIsTx,
  input  logic               modeNew,
  output logic               outValid,
  input  logic               outReady,
  output logic [STAMP_W-1:0] outNs,
  output logic               outIsTx,
  output logic               outNoStamp
);
  pipeStrobe_t strobe;

  stamp_norm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  stamp_norm_dp #(.SPLIT_W(16)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inStamp    (inStamp),
    .inIsTx     (inIsTx),
    .modeNew    (modeNew),
    .outNs      (outNs),
    .outIsTx    (outIsTx),
    .outNoStamp (outNoStamp)
  );
endmodule

// File: rtl/stamp_norm_chk.sv
module stamp_norm_chk
  import stamp_norm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [STAMP_W-1:0] outNs,
  input logic               outIsTx,
  input logic               outNoStamp
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outNs) && $stable(outIsTx) && $stable(outNoStamp)); // R7

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R7

  AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady, 2)); // R6

  AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outNoStamp |-> outIsTx && outNs == '0); // R5

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !outValid); // R9
endmodule

bind stamp_normalizer stamp_norm_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .outValid   (outValid),
  .outReady   (outReady),
  .outNs      (outNs),
  .outIsTx    (outIsTx),
  .outNoStamp (outNoStamp)
);

// File: tb/stamp_normalizer_bench.sv
module stamp_normalizer_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [63:0] inStamp;
  logic        inIsTx;
  logic        modeNew;
  logic        outValid;
  logic        outReady;
  logic [63:0] outNs;
  logic        outIsTx;
  logic        outNoStamp;

  typedef struct packed {
    logic        noStamp;
    logic        isTx;
    logic [2:0]  kind;
    logic [63:0] ns;
  } expItem_t;

  expItem_t    expQ[$];
  int          nCompared = 0;
  int          nMismatched = 0;
  bit          done = 1'b0;
  logic        prevStall = 1'b0;
  logic [63:0] prevNs = '0;

  always #2.5 clk = ~clk;

  stamp_normalizer u_stamp_normalizer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inStamp(inStamp), .inIsTx(inIsTx), .modeNew(modeNew),
    .outValid(outValid), .outReady(outReady), .outNs(outNs),
    .outIsTx(outIsTx), .outNoStamp(outNoStamp)
  );

  function automatic string tagOf(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic expItem_t expOf(input logic [63:0] v, input logic tx, input logic m);
    expItem_t e;
    e.isTx = tx;
    e.noStamp = 1'b0;
    if (tx && v == 64'd1) begin
      e.noStamp = 1'b1; e.ns = '0; e.kind = 3'd4;
    end else if (m) begin
      e.ns = {32'd0, v[63:32]} * 64'd1000000000 + {32'd0, v[31:0]};
      e.kind = tx ? 3'd1 : 3'd0;
    end else if (tx) begin
      e.ns = v; e.kind = 3'd3;
    end else begin
      for (int b = 0; b < 8; b++) e.ns[b*8 +: 8] = v[(7-b)*8 +: 8];
      e.kind = 3'd2;
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [63:0] v, input logic tx,
                      input logic m, input logic oR);
    expItem_t e;
    @(negedge clk);
    inValid = iv; inStamp = v; inIsTx = tx; modeNew = m; outReady = oR;
    #1;
    if (prevStall) begin
      check("R7 held value", outNs, prevNs);
      check("R7 held valid", {63'd0, outValid}, 64'd1);
    end
    if (outValid && !outReady) check("R7 input blocked", {63'd0, inReady}, 64'd0);
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected result", 64'd1, 64'd0);
      end else begin
        e = expQ.pop_front();
        check(tagOf(e.kind), outNs, e.ns);
        check({tagOf(e.kind), " empty flag"}, {63'd0, outNoStamp}, {63'd0, e.noStamp});
        check("R6 direction flag", {63'd0, outIsTx}, {63'd0, e.isTx});
      end
    end
    if (inValid && inReady) expQ.push_back(expOf(v, tx, m));
    prevStall = outValid && !outReady;
    prevNs = outNs;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nMismatched++;
      nCompared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic tx, m;
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; inStamp = '0; inIsTx = 1'b0; modeNew = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 idle in reset", {63'd0, outValid}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    #1 check("R9 idle after reset", {63'd0, outValid}, 64'd0);

    // R6: exact latency
    step(1'b1, 64'h0000_0003_0000_0007, 1'b0, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    check("R6 not yet valid", {63'd0, outValid}, 64'd0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1);
    check("R6 valid at two", {63'd0, outValid}, 64'd1);
    drain();

    // Directed corners
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1); // R1 max
    step(1'b1, 64'h0000_0000_3B9A_C9FF, 1'b1, 1'b1, 1'b1); // R2 zero seconds
    step(1'b1, 64'h0102_0304_0506_0708, 1'b0, 1'b0, 1'b1); // R3
    step(1'b1, 64'h0102_0304_0506_0708, 1'b1, 1'b0, 1'b1); // R4
    step(1'b1, 64'd1, 1'b1, 1'b0, 1'b1);                   // R5 legacy
    step(1'b1, 64'd1, 1'b1, 1'b1, 1'b1);                   // R5 new
    step(1'b1, 64'd1, 1'b0, 1'b0, 1'b1);                   // R5 rx of one swaps
    step(1'b1, 64'd1, 1'b0, 1'b1, 1'b1);                   // R5 rx of one converts
    // R8: mode flips right after acceptance
    step(1'b1, 64'h0000_0010_0000_0020, 1'b0, 1'b1, 1'b1);
    step(1'b0, 64'h0000_0010_0000_0020, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    drain();

    // R10: back-to-back burst
    for (int i = 0; i < 10; i++) begin
      step(1'b1, {$urandom, $urandom}, 1'(i % 2), 1'(i % 3 == 0), 1'b1);
      check("R10 ready in burst", {63'd0, inReady}, 64'd1);
    end
    drain();

    // R7: stall holds data
    for (int i = 0; i < 6; i++) step(1'b1, 64'h1111_0000_2222_0000 + 64'(i), 1'b0, 1'b1, 1'b0);
    drain();

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      tx = 1'($urandom % 2);
      m  = 1'($urandom % 2);
      v  = (tx && ($urandom % 8 == 0)) ? 64'd1 : {$urandom, $urandom};
      step(1'($urandom % 10 < 7), v, tx, m, 1'($urandom % 10 < 7));
    end
    drain();
    check("R7 nothing lost", 64'(expQ.size()), 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule